// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port Controller

This block owns the configuration and data state of a six-pin general-purpose I/O port. Software reaches four registers through a simple synchronous bus made of an address, a write strobe, write data and combinational read data. The four registers hold the pin data, the pin direction, the pulling-device enables and the slew-rate enables. From that state the block drives, for each pin, an output-enable, an output value, a pull-enable and a slew-enable toward the pad ring. It also takes in the raw pin levels and passes them through a two-flop synchronizer.

Reading the data register depends on direction. A pin set as an input returns its synchronized live level. A pin set as an output returns the bit last written. Only pins 5, 4, 1 and 0 can drive. Pins 3 and 2 are input-only.

A peripheral can take over the drive of any pin through a per-pin override enable and value. While a pin is being driven, whether by the port or by a peripheral, its pulling device is held off, whatever its pull-enable bit says.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the data, direction, pull and slew registers are all zero, so every pad output-enable, pull-enable and slew-enable is 0.
- R2: A write at offset 1 (direction), 2 (pull) or 3 (slew) takes effect at the clock edge that samples the strobe. A read of these offsets returns the register in bits 5:0 and 0 in bits 7:6.
- R3: A read at offset 0 returns the latched data bit for each pin whose direction bit is 1. For each pin whose direction bit is 0 it returns the pin level, delayed by a two-flop synchronizer: the level is still old one edge after it changes and is new after the second edge.
- R4: A data write latches all six bits, including those of input pins. A pin later switched to output drives the latched value.
- R5: With direction bit 1 and no override, the pad output-enable is 1 and the output value is the data bit. With direction bit 0 and no override, the output-enable is 0.
- R6: The direction bits for pins 3 and 2 are fixed at 0. Writes to them are ignored and they read back as 0.
- R7: The pad pull-enable of a pin is 1 only when its pull bit is set and its pad output-enable is 0.
- R8: While a pin's override enable is 1, its output-enable is 1 and its output value equals the override value. The offset-0 read of that pin still follows its own direction bit.
- R9: The slew-enable outputs equal the slew register.
- R10: Offsets 4 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on bus_addr) |
| pin_in | input | 6 | Raw pin levels |
| perif_en | input | 6 | Per-pin peripheral override enable |
| perif_val | input | 6 | Per-pin peripheral drive value |
| pad_oe | output | 6 | Per-pin output driver enable |
| pad_out | output | 6 | Per-pin output value |
| pad_pull_en | output | 6 | Per-pin pulling device enable |
| pad_slew_en | output | 6 | Per-pin slew-rate control enable |

## Verification
Directed cases come first:
- a data write made while every pin is an input, followed by a switch to output, which separates latching from driving;
- all-ones direction writes, which expose the fixed input-only pins;
- pull enables set together with port and peripheral drive, which isolates each source of the pull interlock;
- a pin change sampled one and two edges later, which pins down the synchronizer latency.

A seeded random phase then mixes register writes to all eight offsets, random pin levels and random override patterns. After each step it compares every pad output and every read offset against a model held in the bench. This catches direction-mux and priority errors that the directed patterns could miss.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 6;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_PULL = 3'd2,
        SEL_SLEW = 3'd3,
        SEL_NONE = 3'd7
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            3'd0:    s = SEL_DATA;
            3'd1:    s = SEL_DIR;
            3'd2:    s = SEL_PULL;
            3'd3:    s = SEL_SLEW;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= raw_in;
                else            stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_port_pkg::*;
#(
    parameter int             W        = PORT_W,
    parameter logic [W-1:0]   DIR_MASK = 6'b110011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_sel_e     wr_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pull_q,
    output logic [W-1:0] slew_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pull_q <= '0;
            slew_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_DATA: data_q <= wr_bits;
                SEL_PULL: pull_q <= wr_bits;
                SEL_SLEW: slew_q <= wr_bits;
                default:  ;
            endcase
        end
    end

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_dir
            if (DIR_MASK[b]) begin : g_ctl
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)                          dir_q[b] <= 1'b0;
                    else if (wr_en && wr_sel == SEL_DIR) dir_q[b] <= wr_bits[b];
                end
            end else begin : g_fixed
                assign dir_q[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int W = 6
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pull_q,
    input  logic [W-1:0] slew_q,
    input  logic [W-1:0] perif_en,
    input  logic [W-1:0] perif_val,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pull_en,
    output logic [W-1:0] pad_slew_en
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_pin
            always_comb begin
                if (perif_en[b]) begin
                    pad_oe[b]  = 1'b1;
                    pad_out[b] = perif_val[b];
                end else begin
                    pad_oe[b]  = dir_q[b];
                    pad_out[b] = dir_q[b] & data_q[b];
                end
                pad_pull_en[b] = pull_q[b] & ~pad_oe[b];
                pad_slew_en[b] = slew_q[b];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int DW = DATA_W
) (
    input  reg_sel_e      rd_sel,
    input  logic [W-1:0]  data_q,
    input  logic [W-1:0]  dir_q,
    input  logic [W-1:0]  pull_q,
    input  logic [W-1:0]  slew_q,
    input  logic [W-1:0]  pin_sync,
    output logic [DW-1:0] rdata
);
    logic [W-1:0] data_view;

    always_comb begin
        data_view = (dir_q & data_q) | (~dir_q & pin_sync);
        rdata     = '0;
        unique case (rd_sel)
            SEL_DATA: rdata[W-1:0] = data_view;
            SEL_DIR:  rdata[W-1:0] = dir_q;
            SEL_PULL: rdata[W-1:0] = pull_q;
            SEL_SLEW: rdata[W-1:0] = slew_q;
            default:  rdata        = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter logic [PORT_W-1:0] DIR_MASK = 6'b110011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] perif_en,
    input  logic [PORT_W-1:0] perif_val,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pull_en,
    output logic [PORT_W-1:0] pad_slew_en
);
    reg_sel_e          sel;
    logic [PORT_W-1:0] data_q, dir_q, pull_q, slew_q, pin_sync;
    logic              unused_hi;

    assign sel       = decode_offset(bus_addr);
    assign unused_hi = ^bus_wdata[DATA_W-1:PORT_W];

    gpio_in_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(pin_sync)
    );

    gpio_reg_bank #(.W(PORT_W), .DIR_MASK(DIR_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(sel), .wr_en(bus_wr),
        .wr_bits(bus_wdata[PORT_W-1:0]),
        .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q)
    );

    gpio_pin_drive #(.W(PORT_W)) u_drive (
        .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q),
        .perif_en(perif_en), .perif_val(perif_val),
        .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pull_en(pad_pull_en), .pad_slew_en(pad_slew_en)
    );

    gpio_read_mux #(.W(PORT_W), .DW(DATA_W)) u_rmux (
        .rd_sel(sel), .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q),
        .slew_q(slew_q), .pin_sync(pin_sync), .rdata(bus_rdata)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter logic [PORT_W-1:0] DIR_MASK = 6'b110011
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] perif_en,
    input logic [PORT_W-1:0] perif_val,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_pull_en,
    input logic [PORT_W-1:0] pad_slew_en
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == perif_en) && (pad_slew_en == '0));

    a_r7_pull_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pull_en) == '0);

    a_r6_fixed_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~perif_en & ~DIR_MASK) == '0);

    a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
        ((perif_en & ~pad_oe) == '0) && ((perif_en & (pad_out ^ perif_val)) == '0));

    a_r9_slew_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> (pad_slew_en == $past(bus_wdata[PORT_W-1:0])));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 3'd4) |-> (bus_rdata == '0));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PORT_W] == '0);
endmodule

bind gpio_port_ctrl gpio_port_chk #(.DIR_MASK(DIR_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .perif_en(perif_en),
    .perif_val(perif_val), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_en(pad_pull_en), .pad_slew_en(pad_slew_en)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] pin_in = '0, perif_en = '0, perif_val = '0;
    logic [5:0] pad_oe, pad_out, pad_pull_en, pad_slew_en;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    localparam logic [5:0] MASK = 6'b110011;
    logic [5:0] m_data = '0, m_dir = '0, m_pull = '0, m_slew = '0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl u_dut (.*);

    function automatic logic [5:0] e_oe();
        return perif_en | m_dir;
    endfunction
    function automatic logic [5:0] e_out();
        return (perif_en & perif_val) | (~perif_en & m_dir & m_data);
    endfunction
    function automatic logic [5:0] e_pull();
        return m_pull & ~e_oe();
    endfunction
    function automatic logic [7:0] e_read(input logic [2:0] a);
        case (a)
            3'd0: return {2'b0, (m_dir & m_data) | (~m_dir & pin_in)};
            3'd1: return {2'b0, m_dir};
            3'd2: return {2'b0, m_pull};
            3'd3: return {2'b0, m_slew};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            3'd0: m_data = d[5:0];
            3'd1: m_dir  = d[5:0] & MASK;
            3'd2: m_pull = d[5:0];
            3'd3: m_slew = d[5:0];
            default: ;
        endcase
    endtask

    task automatic rd_check(input logic [2:0] a, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, e_read(a));
    endtask

    task automatic pads_check(input string tag);
        #1;
        check({tag, " R5/R8 oe"}, {2'b0, pad_oe}, {2'b0, e_oe()});
        check({tag, " R5/R8 out"}, {2'b0, pad_out & e_oe()}, {2'b0, e_out() & e_oe()});
        check({tag, " R7 pull"}, {2'b0, pad_pull_en}, {2'b0, e_pull()});
        check({tag, " R9 slew"}, {2'b0, pad_slew_en}, {2'b0, m_slew});
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        pads_check("R1");
        for (int a = 0; a < 4; a++) rd_check(3'(a), "R1 reset read");

        // R4 latch while input, then drive
        pin_in = 6'b000000;
        wr(3'd0, 8'hFF);
        settle();
        check("R4 no drive as input", {2'b0, pad_oe}, 8'h00);
        rd_check(3'd0, "R4/R3 input reads pin");
        wr(3'd1, 8'hFF);
        check("R4 latched drive", {2'b0, pad_out}, {2'b0, MASK});
        check("R6 fixed pins oe", {2'b0, pad_oe}, {2'b0, MASK});
        rd_check(3'd1, "R6 dir readback");
        rd_check(3'd0, "R3 output reads latch");
        wr(3'd0, 8'h0F);
        pads_check("R5 drive");

        // R3 synchronizer latency on pin 2 (input-only)
        @(negedge clk);
        pin_in = 6'b000100;
        @(negedge clk);
        bus_addr = 3'd0; #1;
        check("R3 one edge old", bus_rdata & 8'h04, 8'h00);
        @(negedge clk);
        bus_addr = 3'd0; #1;
        check("R3 two edges new", bus_rdata & 8'h04, 8'h04);

        // R7 interlock and R8 override
        wr(3'd2, 8'h3F);
        pads_check("R7 port drive");
        wr(3'd1, 8'h00);
        perif_en = 6'b001100; perif_val = 6'b001000;
        pads_check("R8 periph");
        rd_check(3'd0, "R8 read follows dir");
        perif_en = '0;

        // R2 slew/pull write, R10 unmapped
        wr(3'd3, 8'hEA);
        pads_check("R2 slew write");
        rd_check(3'd3, "R2 upper bits zero");
        wr(3'd5, 8'hFF);
        for (int a = 0; a < 8; a++) rd_check(3'(a), "R10 unmapped");

        // random phase
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 1) == 1)
                wr(3'($urandom_range(0, 7)), 8'($urandom));
            pin_in    = 6'($urandom);
            perif_en  = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h00;
            perif_val = 6'($urandom);
            settle();
            pads_check("rand");
            rd_check(3'($urandom_range(0, 7)), "rand R3/R2/R10 read");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule